// File: doc/BRIEF.md
# Pull-Driven Interaction Queue

This block sits in front of a protocol state machine and buffers the interactions that producers send to it. Each interaction carries a small identifier and a payload. Producers push interactions in. The state machine does not receive them unasked. It pulses a next request, and one clock later it gets exactly one answer. The answer is either the oldest stored interaction or an explicit no-message pulse when nothing is waiting. The consumer never sees two interactions at the same time and never stalls waiting for data.

A push can also be marked for forwarding. A forwarded interaction is not stored locally. It is handed to one of several child queues, chosen by a child index given with the push, and appears on a registered forwarding port one cycle later. Level outputs report an empty queue and a full queue. A sticky flag records any push that was lost because the queue was full.

The response logic is a three-state machine: `RSP_IDLE` (no answer this cycle), `RSP_DELIVER` (a valid interaction is presented) and `RSP_NOMSG` (the no-message pulse is presented). Every state is re-entered at each clock edge from the current inputs, as follows:
- A next request when the queue holds at least one entry leads to `RSP_DELIVER`.
- A next request when the queue is empty leads to `RSP_NOMSG`.
- No request leads to `RSP_IDLE`.

There are no other transitions. Reset forces `RSP_IDLE`.

Top module: `interaction_queue`

## Requirements
- R1: Stored interactions are delivered in the order they were accepted, first in, first out.
- R2: A next request while the queue holds an entry produces, one cycle later, a one-cycle `rsp_valid` pulse carrying that oldest entry's identifier and payload, and removes the entry.
- R3: A next request while the queue is empty produces, one cycle later, a one-cycle `rsp_no_msg` pulse with `rsp_valid` low and `rsp_id`/`rsp_data` driven to zero.
- R4: `rsp_valid` and `rsp_no_msg` are never high together, and both stay low in any cycle that does not follow a next request.
- R5: A local push and a next request in the same cycle on an empty queue answer with no-message; the pushed entry is stored and is delivered by the following request.
- R6: A local push while the queue holds DEPTH entries (judged before any pop in the same cycle) is discarded without changing the stored contents, and it sets `overflow`, which then stays high until reset.
- R7: `empty` is high exactly when zero entries are stored and `full` is high exactly when DEPTH entries are stored, both updated at the clock edge that changes the count.
- R8: A push with `push_fwd` high is not stored; one cycle later `fwd_valid` pulses for one cycle with the child index, identifier and payload of that push.
- R9: A forwarded push whose child index is NUM_CHILD or larger is discarded: `fwd_valid` stays low and nothing is stored.
- R10: Synchronous active-high reset empties the queue, clears `overflow`, and drives `rsp_valid`, `rsp_no_msg`, `rsp_id`, `rsp_data` and `fwd_valid` to zero.
- R11: A local push and a next request in the same cycle on a non-empty, non-full queue deliver the old head and append the new entry, leaving the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| push_valid | input | 1 | Push an interaction this cycle |
| push_fwd | input | 1 | Forward the push to a child instead of storing it |
| push_child | input | CHILD_W | Child index for a forwarded push |
| push_id | input | ID_W | Interaction identifier |
| push_data | input | PAY_W | Interaction payload |
| next_req | input | 1 | Consumer asks for the next interaction |
| rsp_valid | output | 1 | Delivered interaction is presented |
| rsp_no_msg | output | 1 | Answer to a request on an empty queue |
| rsp_id | output | ID_W | Delivered identifier, zero otherwise |
| rsp_data | output | PAY_W | Delivered payload, zero otherwise |
| empty | output | 1 | No entries stored |
| full | output | 1 | DEPTH entries stored |
| overflow | output | 1 | Sticky: a local push was lost to a full queue |
| fwd_valid | output | 1 | Forwarded interaction presented to a child |
| fwd_child | output | CHILD_W | Destination child index |
| fwd_id | output | ID_W | Forwarded identifier |
| fwd_data | output | PAY_W | Forwarded payload |

## Verification
The bench builds the queue with DEPTH set to 4 and NUM_CHILD set to 3. Keeping the queue shallow lets a handful of pushes reach the full boundary. From there the bench covers the dropped push, the case where a push and a pop meet on a full queue, and the sticky overflow flag. With three children the child index is two bits wide, so the index value 3 exists but is out of range, and the bench uses it to exercise the discard rule for forwarded pushes. Pointer wrap-around is reached by draining the queue after a refill.

// File: rtl/iq_pkg.sv
package iq_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE    = 2'd0,
        RSP_DELIVER = 2'd1,
        RSP_NOMSG   = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/iq_store.sv
module iq_store #(
    parameter int DEPTH = 8,
    parameter int ID_W  = 4,
    parameter int PAY_W = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_req,
    input  logic [ID_W-1:0]  push_id,
    input  logic [PAY_W-1:0] push_data,
    input  logic             pop_req,
    output logic [ID_W-1:0]  head_id,
    output logic [PAY_W-1:0] head_data,
    output logic [CNT_W-1:0] count,
    output logic             is_empty,
    output logic             is_full,
    output logic             overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

    logic [ID_W-1:0]  slot_id   [DEPTH];
    logic [PAY_W-1:0] slot_data [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             accept, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    assign is_empty = (count == '0);
    assign is_full  = (count == CNT_W'(DEPTH));
    assign accept   = push_req && !is_full;
    assign pop_ok   = pop_req && !is_empty;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (accept && (wr_ptr == PTR_W'(g))) begin
                slot_id[g]   <= push_id;
                slot_data[g] <= push_data;
            end
        end
    end

    assign head_id   = slot_id[rd_ptr];
    assign head_data = slot_data[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (pop_ok) rd_ptr <= bump(rd_ptr);
            unique case ({accept, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push_req && is_full) overflow <= 1'b1;
        end
    end

endmodule

// File: rtl/iq_resp_fsm.sv
module iq_resp_fsm
    import iq_pkg::*;
#(
    parameter int ID_W  = 4,
    parameter int PAY_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             next_req,
    input  logic             q_empty,
    input  logic [ID_W-1:0]  head_id,
    input  logic [PAY_W-1:0] head_data,
    output logic             pop_req,
    output logic             rsp_valid,
    output logic             rsp_no_msg,
    output logic [ID_W-1:0]  rsp_id,
    output logic [PAY_W-1:0] rsp_data
);
    rsp_state_e       state, state_nx;
    logic [ID_W-1:0]  held_id;
    logic [PAY_W-1:0] held_data;

    assign pop_req = next_req && !q_empty;

    always_comb begin
        if (!next_req)    state_nx = RSP_IDLE;
        else if (q_empty) state_nx = RSP_NOMSG;
        else              state_nx = RSP_DELIVER;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= RSP_IDLE;
            held_id   <= '0;
            held_data <= '0;
        end else begin
            state <= state_nx;
            if (pop_req) begin
                held_id   <= head_id;
                held_data <= head_data;
            end
        end
    end

    always_comb begin
        rsp_valid  = 1'b0;
        rsp_no_msg = 1'b0;
        rsp_id     = '0;
        rsp_data   = '0;
        unique case (state)
            RSP_IDLE: ;
            RSP_DELIVER: begin
                rsp_valid = 1'b1;
                rsp_id    = held_id;
                rsp_data  = held_data;
            end
            RSP_NOMSG: rsp_no_msg = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/iq_fwd.sv
module iq_fwd #(
    parameter int NUM_CHILD = 2,
    parameter int CHILD_W   = 1,
    parameter int ID_W      = 4,
    parameter int PAY_W     = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fwd_req,
    input  logic [CHILD_W-1:0] child,
    input  logic [ID_W-1:0]    id,
    input  logic [PAY_W-1:0]   data,
    output logic               fwd_valid,
    output logic [CHILD_W-1:0] fwd_child,
    output logic [ID_W-1:0]    fwd_id,
    output logic [PAY_W-1:0]   fwd_data
);
    localparam logic [CHILD_W:0] CHILD_LIMIT = (CHILD_W + 1)'(NUM_CHILD);

    logic in_range;
    assign in_range = ({1'b0, child} < CHILD_LIMIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_valid <= 1'b0;
            fwd_child <= '0;
            fwd_id    <= '0;
            fwd_data  <= '0;
        end else begin
            fwd_valid <= fwd_req && in_range;
            if (fwd_req && in_range) begin
                fwd_child <= child;
                fwd_id    <= id;
                fwd_data  <= data;
            end
        end
    end

endmodule

// File: rtl/interaction_queue.sv
module interaction_queue #(
    parameter int DEPTH     = 8,
    parameter int ID_W      = 4,
    parameter int PAY_W     = 16,
    parameter int NUM_CHILD = 2,
    parameter int CHILD_W   = (NUM_CHILD > 2) ? $clog2(NUM_CHILD) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               push_valid,
    input  logic               push_fwd,
    input  logic [CHILD_W-1:0] push_child,
    input  logic [ID_W-1:0]    push_id,
    input  logic [PAY_W-1:0]   push_data,
    input  logic               next_req,
    output logic               rsp_valid,
    output logic               rsp_no_msg,
    output logic [ID_W-1:0]    rsp_id,
    output logic [PAY_W-1:0]   rsp_data,
    output logic               empty,
    output logic               full,
    output logic               overflow,
    output logic               fwd_valid,
    output logic [CHILD_W-1:0] fwd_child,
    output logic [ID_W-1:0]    fwd_id,
    output logic [PAY_W-1:0]   fwd_data
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             push_local, push_remote, pop_req;
    logic [ID_W-1:0]  head_id;
    logic [PAY_W-1:0] head_data;
    logic [CNT_W-1:0] count;

    assign push_local  = push_valid && !push_fwd;
    assign push_remote = push_valid && push_fwd;

    iq_store #(.DEPTH(DEPTH), .ID_W(ID_W), .PAY_W(PAY_W), .CNT_W(CNT_W)) u_store (
        .clk(clk), .rst(rst),
        .push_req(push_local), .push_id(push_id), .push_data(push_data),
        .pop_req(pop_req),
        .head_id(head_id), .head_data(head_data), .count(count),
        .is_empty(empty), .is_full(full), .overflow(overflow)
    );

    iq_resp_fsm #(.ID_W(ID_W), .PAY_W(PAY_W)) u_fsm (
        .clk(clk), .rst(rst),
        .next_req(next_req), .q_empty(empty),
        .head_id(head_id), .head_data(head_data),
        .pop_req(pop_req),
        .rsp_valid(rsp_valid), .rsp_no_msg(rsp_no_msg),
        .rsp_id(rsp_id), .rsp_data(rsp_data)
    );

    iq_fwd #(.NUM_CHILD(NUM_CHILD), .CHILD_W(CHILD_W), .ID_W(ID_W), .PAY_W(PAY_W)) u_fwd (
        .clk(clk), .rst(rst),
        .fwd_req(push_remote), .child(push_child), .id(push_id), .data(push_data),
        .fwd_valid(fwd_valid), .fwd_child(fwd_child),
        .fwd_id(fwd_id), .fwd_data(fwd_data)
    );

endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
    parameter int NUM_CHILD = 2,
    parameter int CHILD_W   = 1
) (
    input logic               clk,
    input logic               rst,
    input logic               push_valid,
    input logic               push_fwd,
    input logic [CHILD_W-1:0] push_child,
    input logic               next_req,
    input logic               rsp_valid,
    input logic               rsp_no_msg,
    input logic               empty,
    input logic               full,
    input logic               overflow,
    input logic               fwd_valid
);
    localparam logic [CHILD_W:0] CHILD_LIMIT = (CHILD_W + 1)'(NUM_CHILD);

    a_r4_exclusive_answer: assert property (@(posedge clk) disable iff (rst)
        !(rsp_valid && rsp_no_msg));

    a_r4_no_unasked_answer: assert property (@(posedge clk) disable iff (rst)
        !next_req |=> (!rsp_valid && !rsp_no_msg));

    a_r2_deliver_when_stored: assert property (@(posedge clk) disable iff (rst)
        (next_req && !empty) |=> rsp_valid);

    a_r3_nomsg_when_empty: assert property (@(posedge clk) disable iff (rst)
        (next_req && empty) |=> rsp_no_msg);

    a_r6_overflow_sets: assert property (@(posedge clk) disable iff (rst)
        (push_valid && !push_fwd && full) |=> overflow);

    a_r6_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    a_r7_not_both: assert property (@(posedge clk) disable iff (rst)
        !(empty && full));

    a_r8_fwd_not_stored: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_fwd && !next_req) |=> ($stable(empty) && $stable(full)));

    a_r9_bad_child_dropped: assert property (@(posedge clk) disable iff (rst)
        (push_valid && push_fwd && ({1'b0, push_child} >= CHILD_LIMIT)) |=> !fwd_valid);

endmodule

bind interaction_queue iq_checker #(.NUM_CHILD(NUM_CHILD), .CHILD_W(CHILD_W)) u_chk (
    .clk(clk), .rst(rst), .push_valid(push_valid), .push_fwd(push_fwd),
    .push_child(push_child), .next_req(next_req), .rsp_valid(rsp_valid),
    .rsp_no_msg(rsp_no_msg), .empty(empty), .full(full), .overflow(overflow),
    .fwd_valid(fwd_valid)
);

// File: tb/interaction_queue_tb.sv
module interaction_queue_tb;
    localparam int DEPTH = 4;
    localparam int ID_W = 4;
    localparam int PAY_W = 16;
    localparam int NUM_CHILD = 3;
    localparam int CHILD_W = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic push_valid = 1'b0, push_fwd = 1'b0, next_req = 1'b0;
    logic [CHILD_W-1:0] push_child = '0;
    logic [ID_W-1:0] push_id = '0;
    logic [PAY_W-1:0] push_data = '0;
    logic rsp_valid, rsp_no_msg, empty, full, overflow, fwd_valid;
    logic [ID_W-1:0] rsp_id, fwd_id;
    logic [PAY_W-1:0] rsp_data, fwd_data;
    logic [CHILD_W-1:0] fwd_child;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    interaction_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .PAY_W(PAY_W),
                        .NUM_CHILD(NUM_CHILD), .CHILD_W(CHILD_W)) u_dut (
        .clk(clk), .rst(rst), .push_valid(push_valid), .push_fwd(push_fwd),
        .push_child(push_child), .push_id(push_id), .push_data(push_data),
        .next_req(next_req), .rsp_valid(rsp_valid), .rsp_no_msg(rsp_no_msg),
        .rsp_id(rsp_id), .rsp_data(rsp_data), .empty(empty), .full(full),
        .overflow(overflow), .fwd_valid(fwd_valid), .fwd_child(fwd_child),
        .fwd_id(fwd_id), .fwd_data(fwd_data)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus, then return at the next falling edge,
    // where the outputs show the result of that rising edge.
    task automatic step(input logic pv, input logic pf, input logic [CHILD_W-1:0] ch,
                        input logic [ID_W-1:0] id, input logic [PAY_W-1:0] d,
                        input logic nr);
        push_valid = pv; push_fwd = pf; push_child = ch;
        push_id = id; push_data = d; next_req = nr;
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0; push_fwd = 1'b0; push_child = '0;
        push_id = '0; push_data = '0; next_req = 1'b0;
    endtask

    task automatic push(input logic [ID_W-1:0] id, input logic [PAY_W-1:0] d);
        step(1'b1, 1'b0, '0, id, d, 1'b0);
    endtask

    task automatic expect_msg(input string req, input logic [ID_W-1:0] id,
                              input logic [PAY_W-1:0] d);
        step(1'b0, 1'b0, '0, '0, '0, 1'b1);
        check(req, "rsp_valid", 32'(rsp_valid), 32'd1);
        check(req, "rsp_no_msg", 32'(rsp_no_msg), 32'd0);
        check(req, "rsp_id", 32'(rsp_id), 32'(id));
        check(req, "rsp_data", 32'(rsp_data), 32'(d));
    endtask

    task automatic expect_none(input string req);
        step(1'b0, 1'b0, '0, '0, '0, 1'b1);
        check(req, "rsp_no_msg", 32'(rsp_no_msg), 32'd1);
        check(req, "rsp_valid", 32'(rsp_valid), 32'd0);
        check(req, "rsp_id", 32'(rsp_id), 32'd0);
        check(req, "rsp_data", 32'(rsp_data), 32'd0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R10", "empty", 32'(empty), 32'd1);
        check("R10", "full", 32'(full), 32'd0);
        check("R10", "overflow", 32'(overflow), 32'd0);
        check("R10", "rsp_valid", 32'(rsp_valid), 32'd0);
        check("R10", "rsp_no_msg", 32'(rsp_no_msg), 32'd0);
        check("R10", "fwd_valid", 32'(fwd_valid), 32'd0);
    endtask

    task automatic t_empty_request();
        expect_none("R3");
        step(1'b0, 1'b0, '0, '0, '0, 1'b0);
        check("R4", "rsp_no_msg idle", 32'(rsp_no_msg), 32'd0);
        check("R4", "rsp_valid idle", 32'(rsp_valid), 32'd0);
    endtask

    task automatic t_fifo_order();
        push(4'h1, 16'hA001);
        check("R7", "empty after push", 32'(empty), 32'd0);
        push(4'h2, 16'hB002);
        push(4'h3, 16'hC003);
        expect_msg("R1", 4'h1, 16'hA001);
        step(1'b0, 1'b0, '0, '0, '0, 1'b0);
        check("R2", "single pulse", 32'(rsp_valid), 32'd0);
        expect_msg("R1", 4'h2, 16'hB002);
        expect_msg("R2", 4'h3, 16'hC003);
        check("R7", "empty after drain", 32'(empty), 32'd1);
        expect_none("R3");
    endtask

    task automatic t_full_overflow();
        for (int i = 0; i < DEPTH; i++) push(ID_W'(4 + i), PAY_W'(16'h1000 + i));
        check("R7", "full", 32'(full), 32'd1);
        check("R6", "overflow before drop", 32'(overflow), 32'd0);
        push(4'h8, 16'hDEAD);
        check("R6", "overflow set", 32'(overflow), 32'd1);
        check("R6", "still full", 32'(full), 32'd1);
        // push and pop together on a full queue: push is still lost
        step(1'b1, 1'b0, '0, 4'h9, 16'hBEEF, 1'b1);
        check("R6", "head on full pop", 32'(rsp_id), 32'd4);
        check("R7", "full cleared", 32'(full), 32'd0);
        for (int i = 1; i < DEPTH; i++) expect_msg("R6", ID_W'(4 + i), PAY_W'(16'h1000 + i));
        expect_none("R6");
        check("R6", "overflow sticky", 32'(overflow), 32'd1);
        do_reset();
        check("R10", "overflow cleared", 32'(overflow), 32'd0);
    endtask

    task automatic t_same_cycle_empty();
        step(1'b1, 1'b0, '0, 4'hA, 16'h5A5A, 1'b1);
        check("R5", "no_msg", 32'(rsp_no_msg), 32'd1);
        check("R5", "rsp_valid", 32'(rsp_valid), 32'd0);
        check("R5", "stored", 32'(empty), 32'd0);
        expect_msg("R5", 4'hA, 16'h5A5A);
    endtask

    task automatic t_same_cycle_busy();
        push(4'h1, 16'h0101);
        step(1'b1, 1'b0, '0, 4'h2, 16'h0202, 1'b1);
        check("R11", "rsp_valid", 32'(rsp_valid), 32'd1);
        check("R11", "rsp_id", 32'(rsp_id), 32'd1);
        check("R11", "not empty", 32'(empty), 32'd0);
        expect_msg("R11", 4'h2, 16'h0202);
        expect_none("R11");
    endtask

    task automatic t_forward();
        step(1'b1, 1'b1, 2'd2, 4'h5, 16'hF00D, 1'b0);
        check("R8", "fwd_valid", 32'(fwd_valid), 32'd1);
        check("R8", "fwd_child", 32'(fwd_child), 32'd2);
        check("R8", "fwd_id", 32'(fwd_id), 32'd5);
        check("R8", "fwd_data", 32'(fwd_data), 32'hF00D);
        check("R8", "not stored", 32'(empty), 32'd1);
        step(1'b0, 1'b0, '0, '0, '0, 1'b0);
        check("R8", "one pulse", 32'(fwd_valid), 32'd0);
        step(1'b1, 1'b1, 2'd3, 4'h6, 16'h1234, 1'b0);
        check("R9", "fwd_valid bad child", 32'(fwd_valid), 32'd0);
        check("R9", "not stored", 32'(empty), 32'd1);
        expect_none("R9");
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_empty_request();
        t_fifo_order();
        t_full_overflow();
        t_same_cycle_empty();
        t_same_cycle_busy();
        t_forward();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule